// File: doc/BRIEF.md
# Transmit Interrupt Delay Timer

This block decides when a network transmit path raises its descriptor write-back interrupt. Each time the transmit engine writes a descriptor back, it pulses a strobe and presents two command bits from that descriptor: report-status and delay-enable. A descriptor that asks for status without delay causes an interrupt right away. A descriptor that asks for both starts a countdown, loaded from a programmable 16-bit delay value. The interrupt fires when the countdown runs out.

The countdown steps only on an external unit-tick pulse, so the time base comes from outside the block. Every delayed descriptor restarts the countdown from the full delay value, even while it is already running. An immediate descriptor fires at once and cancels any countdown in progress. The interrupt output is a one-cycle cause pulse, gated by a write-back interrupt enable. The timer state and the current count are brought out for observation.

Top module: `txid_timer`

## Requirements
- R1: When `wbStrobe` is 1 with `wbReportStatus`=1, `wbDelayEnable`=1 and a nonzero `delayValue`, then one cycle later `timerActive` is 1, `timerCount` equals that `delayValue`, and `intPulse` is 0. The caller wires descriptor command bit 3 to `wbReportStatus` and command bit 7 to `wbDelayEnable`.
- R2: A delayed write-back (as in R1) that arrives while the countdown is running reloads `timerCount` with the current `delayValue`. This holds even in the cycle where a tick would have expired the count; in that case no interrupt is raised.
- R3: While active, `timerCount` decreases by exactly 1 per cycle in which `unitTick` is 1, and holds when `unitTick` is 0. A `unitTick` while idle leaves `timerCount` at 0 and `timerActive` at 0.
- R4: A `unitTick` while active with `timerCount`=1 makes the next cycle show `timerActive`=0 and `timerCount`=0. If `wbIntEnable` is 1, `intPulse` is 1 for that one cycle.
- R5: If `wbIntEnable` is 0 when the count expires, the timer still returns to idle with count 0, and `intPulse` stays 0.
- R6: A write-back with `wbReportStatus`=1 and `wbDelayEnable`=0 makes the next cycle show `timerActive`=0 and `timerCount`=0, cancelling any countdown. `intPulse` is 1 in that cycle if `wbIntEnable` is 1, and 0 otherwise.
- R7: A delayed write-back with `delayValue`=0 behaves as an immediate write-back (R6).
- R8: A write-back with `wbReportStatus`=0 has no effect on the timer or on `intPulse`, whatever `wbDelayEnable` is. Command bits presented while `wbStrobe` is 0 also have no effect.
- R9: An immediate write-back in the same cycle as a countdown expiry produces a single one-cycle `intPulse`, and the timer ends idle.
- R10: Synchronous active-high `rst` gives `timerActive`=0, `timerCount`=0 and `intPulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbStrobe | input | 1 | One-cycle pulse per descriptor write-back |
| wbReportStatus | input | 1 | Report-status command bit (descriptor command bit 3) |
| wbDelayEnable | input | 1 | Delay-enable command bit (descriptor command bit 7) |
| delayValue | input | 16 | Programmed countdown length in ticks |
| wbIntEnable | input | 1 | Write-back interrupt enable |
| unitTick | input | 1 | Countdown time-base pulse |
| intPulse | output | 1 | One-cycle write-back interrupt cause |
| timerActive | output | 1 | Countdown running |
| timerCount | output | 16 | Remaining ticks; 0 when idle |

## Verification
The assertions assume that the command bits are meaningful only while `wbStrobe` is high. They also assume that `delayValue` and `wbIntEnable` are steady registers, so a change to either applies from the cycle it is presented. The expiry and decrement properties also assume that at most one write-back and one tick arrive per cycle. The bench meets these assumptions: it drives a single strobe and a single tick per cycle, and it changes the delay value and the enable only between write-backs. It also deliberately makes a tick coincide with a write-back to check the collision orderings.

// File: rtl/txid_pkg.sv
package txid_pkg;

  typedef enum logic [0:0] {
    TMR_IDLE  = 1'b0,
    TMR_COUNT = 1'b1
  } tmrState_e;

  // Strobes sent from the control FSM to the count datapath.
  typedef struct packed {
    logic loadCount;
    logic clearCount;
    logic decCount;
    logic raiseInt;
  } tmrStrobes_t;

endpackage

// File: rtl/txid_ctrl.sv
module txid_ctrl
  import txid_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wbStrobe,
  input  logic        wbReportStatus,
  input  logic        wbDelayEnable,
  input  logic        wbIntEnable,
  input  logic        unitTick,
  input  logic        delayIsZero,
  input  logic        countIsOne,
  output tmrStrobes_t strobes,
  output logic        timerActive
);

  tmrState_e stateQ, stateD;

  logic reportWb;
  logic wantDelay;
  logic wantNow;
  logic expire;
  logic step;

  always_comb begin
    reportWb  = wbStrobe & wbReportStatus;
    wantDelay = reportWb & wbDelayEnable & ~delayIsZero;
    wantNow   = reportWb & ~wantDelay;
    expire    = (stateQ == TMR_COUNT) & unitTick & countIsOne;
    step      = (stateQ == TMR_COUNT) & unitTick & ~countIsOne;
  end

  // Priority: an immediate write-back first, then a reload, then expiry, then a step.
  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    if (wantNow) begin
      strobes.clearCount = 1'b1;
      strobes.raiseInt   = wbIntEnable;
      stateD             = TMR_IDLE;
    end else if (wantDelay) begin
      strobes.loadCount  = 1'b1;
      stateD             = TMR_COUNT;
    end else if (expire) begin
      strobes.clearCount = 1'b1;
      strobes.raiseInt   = wbIntEnable;
      stateD             = TMR_IDLE;
    end else if (step) begin
      strobes.decCount   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= TMR_IDLE;
    else     stateQ <= stateD;
  end

  assign timerActive = (stateQ == TMR_COUNT);

endmodule

// File: rtl/txid_datapath.sv
module txid_datapath
  import txid_pkg::*;
#(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  tmrStrobes_t        strobes,
  input  logic [DELAY_W-1:0] delayValue,
  output logic               delayIsZero,
  output logic               countIsOne,
  output logic [DELAY_W-1:0] timerCount,
  output logic               intPulse
);

  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic [DELAY_W-1:0] countQ;
  logic               pulseQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= strobes.raiseInt;
      if (strobes.clearCount)     countQ <= '0;
      else if (strobes.loadCount) countQ <= delayValue;
      else if (strobes.decCount)  countQ <= countQ - ONE;
    end
  end

  assign delayIsZero = (delayValue == '0);
  assign countIsOne  = (countQ == ONE);
  assign timerCount  = countQ;
  assign intPulse    = pulseQ;

endmodule

// File: rtl/txid_timer.sv
module txid_timer
  import txid_pkg::*;
#(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wbStrobe,
  input  logic               wbReportStatus,
  input  logic               wbDelayEnable,
  input  logic [DELAY_W-1:0] delayValue,
  input  logic               wbIntEnable,
  input  logic               unitTick,
  output logic               intPulse,
  output logic               timerActive,
  output logic [DELAY_W-1:0] timerCount
);

  tmrStrobes_t strobes;
  logic        delayIsZero;
  logic        countIsOne;

  txid_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .wbStrobe       (wbStrobe),
    .wbReportStatus (wbReportStatus),
    .wbDelayEnable  (wbDelayEnable),
    .wbIntEnable    (wbIntEnable),
    .unitTick       (unitTick),
    .delayIsZero    (delayIsZero),
    .countIsOne     (countIsOne),
    .strobes        (strobes),
    .timerActive    (timerActive)
  );

  txid_datapath #(.DELAY_W(DELAY_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .delayValue  (delayValue),
    .delayIsZero (delayIsZero),
    .countIsOne  (countIsOne),
    .timerCount  (timerCount),
    .intPulse    (intPulse)
  );

endmodule

// File: rtl/txid_checker.sv
module txid_checker #(
  parameter int DELAY_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               wbStrobe,
  input logic               wbReportStatus,
  input logic               wbDelayEnable,
  input logic [DELAY_W-1:0] delayValue,
  input logic               wbIntEnable,
  input logic               unitTick,
  input logic               intPulse,
  input logic               timerActive,
  input logic [DELAY_W-1:0] timerCount
);

  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  assert_delayed_load_R1: assert property (@(posedge clk) disable iff (rst)
    (wbStrobe && wbReportStatus && wbDelayEnable && delayValue != '0)
    |=> (timerActive && timerCount == $past(delayValue) && !intPulse));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (timerActive && unitTick && !wbStrobe && timerCount > ONE)
    |=> (timerActive && timerCount == $past(timerCount) - ONE));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (timerActive && !unitTick && !wbStrobe)
    |=> (timerActive && $stable(timerCount) && !intPulse));

  assert_expiry_fires_R4: assert property (@(posedge clk) disable iff (rst)
    (timerActive && unitTick && timerCount == ONE && !wbStrobe && wbIntEnable)
    |=> (intPulse && !timerActive && timerCount == '0));

  assert_expiry_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    (timerActive && unitTick && timerCount == ONE && !wbStrobe && !wbIntEnable)
    |=> (!intPulse && !timerActive && timerCount == '0));

  assert_immediate_R6: assert property (@(posedge clk) disable iff (rst)
    (wbStrobe && wbReportStatus && !wbDelayEnable)
    |=> (intPulse == $past(wbIntEnable) && !timerActive && timerCount == '0));

  assert_zero_delay_R7: assert property (@(posedge clk) disable iff (rst)
    (wbStrobe && wbReportStatus && wbDelayEnable && delayValue == '0)
    |=> (intPulse == $past(wbIntEnable) && !timerActive));

  assert_no_status_R8: assert property (@(posedge clk) disable iff (rst)
    (!wbReportStatus && !unitTick)
    |=> ($stable(timerCount) && $stable(timerActive) && !intPulse));

  assert_collision_R9: assert property (@(posedge clk) disable iff (rst)
    (timerActive && unitTick && timerCount == ONE && wbStrobe && wbReportStatus
     && !wbDelayEnable && wbIntEnable)
    |=> (intPulse && !timerActive));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !timerActive |-> timerCount == '0);

endmodule

bind txid_timer txid_checker #(.DELAY_W(DELAY_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .wbStrobe       (wbStrobe),
  .wbReportStatus (wbReportStatus),
  .wbDelayEnable  (wbDelayEnable),
  .delayValue     (delayValue),
  .wbIntEnable    (wbIntEnable),
  .unitTick       (unitTick),
  .intPulse       (intPulse),
  .timerActive    (timerActive),
  .timerCount     (timerCount)
);

// File: tb/txid_timer_tb.sv
module txid_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wbStrobe = 1'b0;
  logic        wbReportStatus = 1'b0;
  logic        wbDelayEnable = 1'b0;
  logic [15:0] delayValue = 16'd0;
  logic        wbIntEnable = 1'b1;
  logic        unitTick = 1'b0;
  logic        intPulse;
  logic        timerActive;
  logic [15:0] timerCount;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txid_timer u_dut (
    .clk            (clk),
    .rst            (rst),
    .wbStrobe       (wbStrobe),
    .wbReportStatus (wbReportStatus),
    .wbDelayEnable  (wbDelayEnable),
    .delayValue     (delayValue),
    .wbIntEnable    (wbIntEnable),
    .unitTick       (unitTick),
    .intPulse       (intPulse),
    .timerActive    (timerActive),
    .timerCount     (timerCount)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expectState(input string req, input logic pulse,
                             input logic active, input logic [15:0] count);
    check(req, "intPulse", 32'(intPulse), 32'(pulse));
    check(req, "timerActive", 32'(timerActive), 32'(active));
    check(req, "timerCount", 32'(timerCount), 32'(count));
  endtask

  // Drive one cycle from a falling edge; results are visible on return.
  task automatic apply(input logic wb, input logic rs, input logic dl, input logic tk);
    wbStrobe = wb; wbReportStatus = rs; wbDelayEnable = dl; unitTick = tk;
    @(negedge clk);
    wbStrobe = 1'b0; wbReportStatus = 1'b0; wbDelayEnable = 1'b0; unitTick = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expectState("R10", 1'b0, 1'b0, 16'd0);
    rst = 1'b0;
  endtask

  task automatic testImmediate();
    wbIntEnable = 1'b1;
    apply(1, 1, 0, 0);
    expectState("R6", 1'b1, 1'b0, 16'd0);
    apply(0, 0, 0, 0);
    check("R6", "pulse one cycle", 32'(intPulse), 32'd0);
  endtask

  task automatic testDelayed();
    delayValue = 16'd3;
    apply(1, 1, 1, 0);
    expectState("R1", 1'b0, 1'b1, 16'd3);
    apply(0, 0, 0, 1);
    expectState("R3", 1'b0, 1'b1, 16'd2);
    apply(0, 0, 0, 0);
    expectState("R3", 1'b0, 1'b1, 16'd2);
    apply(0, 0, 0, 1);
    expectState("R3", 1'b0, 1'b1, 16'd1);
    apply(0, 0, 0, 1);
    expectState("R4", 1'b1, 1'b0, 16'd0);
    apply(0, 0, 0, 0);
    check("R4", "pulse one cycle", 32'(intPulse), 32'd0);
  endtask

  task automatic testReload();
    delayValue = 16'd5;
    apply(1, 1, 1, 0);
    apply(0, 0, 0, 1);
    apply(0, 0, 0, 1);
    expectState("R3", 1'b0, 1'b1, 16'd3);
    apply(1, 1, 1, 0);
    expectState("R2", 1'b0, 1'b1, 16'd5);
    delayValue = 16'd1;
    apply(1, 1, 1, 0);
    expectState("R2", 1'b0, 1'b1, 16'd1);
    delayValue = 16'd6;
    apply(1, 1, 1, 1);
    expectState("R2", 1'b0, 1'b1, 16'd6);
    apply(1, 1, 0, 0);
    expectState("R6", 1'b1, 1'b0, 16'd0);
  endtask

  task automatic testIgnored();
    delayValue = 16'd4;
    apply(1, 1, 1, 0);
    apply(1, 0, 1, 0);
    expectState("R8", 1'b0, 1'b1, 16'd4);
    apply(0, 1, 1, 0);
    expectState("R8", 1'b0, 1'b1, 16'd4);
    apply(0, 1, 0, 0);
    expectState("R8", 1'b0, 1'b1, 16'd4);
    apply(1, 1, 0, 0);
    apply(0, 0, 0, 1);
    expectState("R3", 1'b0, 1'b0, 16'd0);
    apply(1, 0, 1, 0);
    expectState("R8", 1'b0, 1'b0, 16'd0);
  endtask

  task automatic testDisabled();
    wbIntEnable = 1'b0;
    delayValue  = 16'd1;
    apply(1, 1, 1, 0);
    expectState("R1", 1'b0, 1'b1, 16'd1);
    apply(0, 0, 0, 1);
    expectState("R5", 1'b0, 1'b0, 16'd0);
    apply(1, 1, 0, 0);
    expectState("R6", 1'b0, 1'b0, 16'd0);
    wbIntEnable = 1'b1;
  endtask

  task automatic testZeroDelay();
    delayValue = 16'd0;
    apply(1, 1, 1, 0);
    expectState("R7", 1'b1, 1'b0, 16'd0);
  endtask

  task automatic testCollision();
    delayValue = 16'd1;
    apply(1, 1, 1, 0);
    apply(1, 1, 0, 1);
    expectState("R9", 1'b1, 1'b0, 16'd0);
    apply(0, 0, 0, 0);
    check("R9", "single pulse", 32'(intPulse), 32'd0);
  endtask

  task automatic testFullRange();
    delayValue = 16'hFFFF;
    apply(1, 1, 1, 0);
    expectState("R1", 1'b0, 1'b1, 16'hFFFF);
    apply(0, 0, 0, 1);
    expectState("R3", 1'b0, 1'b1, 16'hFFFE);
    apply(1, 1, 0, 0);
    expectState("R6", 1'b1, 1'b0, 16'd0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testImmediate();
    testDelayed();
    testReload();
    testIgnored();
    testDisabled();
    testZeroDelay();
    testCollision();
    testFullRange();
    testReset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule